// File: doc/BRIEF.md
# OUT Endpoint Packet Buffer

This block owns the receive storage of a single OUT endpoint in a USB device. The protocol engine writes the bytes of an incoming data packet one at a time and strobes the end of the packet. The block then tells it whether the packet was kept, which decides between ACK and NAK. On the other side, the processor sees a ready flag, a full flag, the byte count of the oldest stored packet and a data byte. It pops bytes one at a time and releases the packet by clearing the ready flag.

The storage holds either one packet or two. Two packets are held only when the configured FIFO size is at least twice the configured maximum packet size and the double-buffer disable bit has been cleared. The disable bit is a register inside the block that comes out of reset set. In two-packet mode, slot 0 starts at byte 0 and slot 1 starts at the maximum packet size. An optional auto-release frees a packet as soon as its last byte has been read, provided that packet was exactly the maximum size.

Top module: `outep_pktbuf`

## Requirements
- R1: `dbl_mode` is 1 exactly when the disable register is 0, `cfg_err` is 0, and `cfg_fifo_bytes` >= 2*`cfg_maxpkt`. Otherwise one packet at a most is held, even if it would fit twice.
- R2: After reset the disable register is 1, so `dbl_mode` = 0. `ready`, `full` and `ep_irq` are 0 and `can_accept` is 1 for a valid configuration.
- R3: In single mode, a kept packet sets `ready` and `full` together on the second rising edge after its end strobe, and `ep_irq` pulses in that same cycle.
- R4: In double mode, the first kept packet sets `ready` while `full` stays 0. `full` becomes 1 on the edge that stores a second packet.
- R5: A `clr_ready` pulse while `ready` is 1 drops `ready` on the next edge. In single mode `full` drops too and `can_accept` returns to 1.
- R6: With `cfg_autoclr` = 1, reading the last byte of a packet whose length equals `cfg_maxpkt` releases it on that read's edge. A shorter packet keeps `ready` at 1 until it is cleared by hand.
- R7: In double mode, clearing `ready` while `full` is 1 drops both on the next edge. `ready` rises again one edge later, with an `ep_irq` pulse, and now shows the second packet.
- R8: `cfg_err` is 1 when `cfg_maxpkt` is 0, when it exceeds `cfg_fifo_bytes`, or when `cfg_fifo_bytes` exceeds the storage depth. While it is 1, `can_accept` is 0.
- R9: With no free slot (single mode and a packet held, or `full` = 1), `can_accept` is 0. A packet that starts in that state is dropped completely.
- R10: Clearing `ready` before all bytes have been read drops the unread bytes. The next byte shown is the first byte of the next packet.
- R11: `rd_count` gives the stored length of the oldest packet, and `rd_byte` gives its bytes in arrival order. Bytes beyond `cfg_maxpkt` are not stored.
- R12: `ep_irq` is a one-cycle pulse on every rise of `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_fifo_bytes | input | AW+1 | Configured FIFO size in bytes |
| cfg_maxpkt | input | AW+1 | Configured maximum packet size |
| dbl_off_we | input | 1 | Write strobe for the double-buffer disable register |
| dbl_off_val | input | 1 | Value written to the disable register |
| cfg_autoclr | input | 1 | Enables release after a full-size packet is drained |
| pkt_wr | input | 1 | Byte valid from the protocol engine |
| pkt_byte | input | 8 | Received byte |
| pkt_end | input | 1 | End of packet (may coincide with the last byte) |
| can_accept | output | 1 | A packet starting now would be kept (ACK) |
| rd_en | input | 1 | Pop one byte of the oldest packet |
| rd_byte | output | 8 | Byte at the read position |
| rd_count | output | AW+1 | Length of the oldest packet |
| clr_ready | input | 1 | Release the oldest packet |
| ready | output | 1 | A packet is available to read |
| full | output | 1 | No free slot remains (per mode) |
| ep_irq | output | 1 | Endpoint interrupt pulse |
| cfg_err | output | 1 | Configuration is invalid |
| dbl_mode | output | 1 | Two-packet mode is active |

## Verification
The bench builds the block with `FIFO_DEPTH` = 16 and a maximum packet size of 8. That makes two-packet mode reachable, and it lets an oversize packet, an exact-size auto-release, and a maximum size above the FIFO size all come up in a few cycles. Raising the maximum to 12 keeps the same storage but breaks the twice-the-size rule, so the fallback to one packet shows up with the disable register already cleared.

// File: rtl/outep_pkg.sv
package outep_pkg;

  // Two-packet operation needs room for two maximum-size packets.
  function automatic logic dbl_allowed(input int fifo, input int maxp, input logic off);
    return !off && (maxp > 0) && (fifo >= 2 * maxp);
  endfunction

  // Invalid when the maximum is zero, larger than the FIFO, or the FIFO exceeds storage.
  function automatic logic cfg_bad(input int fifo, input int maxp, input int depth);
    return (maxp == 0) || (maxp > fifo) || (fifo > depth);
  endfunction

  // Byte offset of a packet slot.
  function automatic int slot_base(input logic slot, input int maxp);
    return slot ? maxp : 0;
  endfunction

endpackage

// File: rtl/outep_mem.sv
module outep_mem #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/outep_flags.sv
module outep_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbl,
  input  logic       commit,
  input  logic       clr_ev,
  output logic [1:0] occ,
  output logic       ready,
  output logic       full,
  output logic       irq,
  output logic       slot_free
);
  logic [1:0] occ_n;

  assign occ_n = occ + {1'b0, commit} - {1'b0, clr_ev};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ   <= 2'd0;
      ready <= 1'b0;
      irq   <= 1'b0;
    end else begin
      occ <= occ_n;
      if (clr_ev) begin
        ready <= 1'b0;
        irq   <= 1'b0;
      end else if (!ready && occ != 2'd0) begin
        ready <= 1'b1;
        irq   <= 1'b1;
      end else begin
        irq   <= 1'b0;
      end
    end
  end

  assign full      = dbl ? (occ == 2'd2) : ready;
  assign slot_free = dbl ? (occ != 2'd2) : (occ == 2'd0);
endmodule

// File: rtl/outep_pktbuf.sv
module outep_pktbuf
  import outep_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int AW = $clog2(FIFO_DEPTH),
  localparam int SW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] cfg_fifo_bytes,
  input  logic [SW-1:0] cfg_maxpkt,
  input  logic          dbl_off_we,
  input  logic          dbl_off_val,
  input  logic          cfg_autoclr,
  input  logic          pkt_wr,
  input  logic [7:0]    pkt_byte,
  input  logic          pkt_end,
  output logic          can_accept,
  input  logic          rd_en,
  output logic [7:0]    rd_byte,
  output logic [SW-1:0] rd_count,
  input  logic          clr_ready,
  output logic          ready,
  output logic          full,
  output logic          ep_irq,
  output logic          cfg_err,
  output logic          dbl_mode
);
  // Disable register, set out of reset
  logic dbl_off_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dbl_off_q <= 1'b1;
    else if (dbl_off_we) dbl_off_q <= dbl_off_val;
  end

  assign cfg_err  = cfg_bad(int'(cfg_fifo_bytes), int'(cfg_maxpkt), FIFO_DEPTH);
  assign dbl_mode = !cfg_err && dbl_allowed(int'(cfg_fifo_bytes), int'(cfg_maxpkt), dbl_off_q);

  // Named internal events
  logic          commit_ev, clear_ev, auto_ev, rd_ok, wr_ok, take_now;
  logic [1:0]    occ;
  logic          slot_free;

  // Write side state
  logic          in_pkt, taking, wslot;
  logic [SW-1:0] wcnt;
  logic [SW-1:0] len_q [2];

  // Read side state
  logic          rslot;
  logic [SW-1:0] rptr;
  logic [SW-1:0] head_len;
  logic [AW-1:0] waddr, raddr;

  assign can_accept = slot_free && !cfg_err;
  assign take_now   = in_pkt ? taking : can_accept;
  assign wr_ok      = pkt_wr && take_now && (wcnt < cfg_maxpkt);
  assign commit_ev  = pkt_end && take_now;
  assign waddr      = AW'(slot_base(wslot, int'(cfg_maxpkt)) + int'(wcnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      taking <= 1'b0;
      wslot  <= 1'b0;
      wcnt   <= '0;
      for (int i = 0; i < 2; i++) len_q[i] <= '0;
    end else if (pkt_end) begin
      in_pkt <= 1'b0;
      wcnt   <= '0;
      if (commit_ev) begin
        len_q[wslot] <= wcnt + SW'(wr_ok);
        wslot        <= dbl_mode ? ~wslot : 1'b0;
      end
    end else if (pkt_wr) begin
      if (!in_pkt) begin
        in_pkt <= 1'b1;
        taking <= can_accept;
      end
      if (wr_ok) wcnt <= wcnt + SW'(1);
    end
  end

  assign head_len = len_q[rslot];
  assign raddr    = AW'(slot_base(rslot, int'(cfg_maxpkt)) + int'(rptr));
  assign rd_ok    = rd_en && ready && (rptr < head_len);
  assign auto_ev  = cfg_autoclr && rd_ok && (head_len == cfg_maxpkt) &&
                    ((rptr + SW'(1)) == head_len);
  assign clear_ev = ready && (clr_ready || auto_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rslot <= 1'b0;
      rptr  <= '0;
    end else if (clear_ev) begin
      rptr  <= '0;
      rslot <= dbl_mode ? ~rslot : 1'b0;
    end else if (rd_ok) begin
      rptr  <= rptr + SW'(1);
    end
  end

  assign rd_count = head_len;

  outep_mem #(.DEPTH(FIFO_DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (waddr),
    .wdata (pkt_byte),
    .raddr (raddr),
    .rdata (rd_byte)
  );

  outep_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbl       (dbl_mode),
    .commit    (commit_ev),
    .clr_ev    (clear_ev),
    .occ       (occ),
    .ready     (ready),
    .full      (full),
    .irq       (ep_irq),
    .slot_free (slot_free)
  );
endmodule

// File: rtl/outep_chk.sv
module outep_chk (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic full,
  input logic ep_irq,
  input logic can_accept,
  input logic dbl_mode,
  input logic cfg_err,
  input logic clear_ev
);
  // R4
  full_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> ready);

  // R9
  no_accept_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !can_accept);

  // R8
  cfg_err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !can_accept);

  // R7
  refill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_mode && clear_ev && full) |=> ((!full && !ready) ##1 (ready && ep_irq)));

  // R12
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ep_irq);

  // R12
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |=> !ep_irq);
endmodule

bind outep_pktbuf outep_chk i_chk (.*);

// File: tb/test_outep_pktbuf.sv
module test_outep_pktbuf;
  localparam int DEPTH = 16;
  localparam int SW = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] cfg_fifo_bytes = SW'(16);
  logic [SW-1:0] cfg_maxpkt = SW'(8);
  logic          dbl_off_we = 1'b0, dbl_off_val = 1'b1, cfg_autoclr = 1'b0;
  logic          pkt_wr = 1'b0, pkt_end = 1'b0, rd_en = 1'b0, clr_ready = 1'b0;
  logic [7:0]    pkt_byte = 8'h00;
  logic          can_accept, ready, full, ep_irq, cfg_err, dbl_mode;
  logic [7:0]    rd_byte;
  logic [SW-1:0] rd_count;

  int total = 0, bad = 0, cur_max = 8;
  bit done = 0;
  byte unsigned exp_q [$];

  always #2.5 clk = ~clk;

  outep_pktbuf #(.FIFO_DEPTH(DEPTH)) i_outep_pktbuf (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Driver: sends a packet and queues the bytes expected to be kept
  task automatic send(int n, int base, bit acc, string req);
    chk(req, int'(can_accept), int'(acc));
    if (n == 0) begin
      pkt_end = 1'b1;
      tick();
    end
    for (int i = 0; i < n; i++) begin
      pkt_wr   = 1'b1;
      pkt_byte = 8'(base + i);
      pkt_end  = (i == n - 1);
      if (acc && i < cur_max) exp_q.push_back(8'(base + i));
      tick();
    end
    pkt_wr  = 1'b0;
    pkt_end = 1'b0;
  endtask

  // Monitor side: pops the expected bytes and compares them with the read port
  task automatic read(int n, string req);
    for (int i = 0; i < n; i++) begin
      if (exp_q.size() == 0) chk({req, " queue"}, 1, 0);
      else chk(req, int'(rd_byte), int'(exp_q.pop_front()));
      rd_en = 1'b1;
      tick();
    end
    rd_en = 1'b0;
  endtask

  task automatic clear();
    clr_ready = 1'b1;
    tick();
    clr_ready = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R2 reset state
    chk("R2 ready", int'(ready), 0);
    chk("R2 full", int'(full), 0);
    chk("R2 irq", int'(ep_irq), 0);
    chk("R2 accept", int'(can_accept), 1);
    chk("R2 dbl_mode", int'(dbl_mode), 0);

    // R3 single-mode store
    send(5, 8'h10, 1, "R3 accept");
    chk("R3 ready early", int'(ready), 0);
    tick();
    chk("R3 ready", int'(ready), 1);
    chk("R3 full", int'(full), 1);
    chk("R12 irq", int'(ep_irq), 1);
    chk("R11 count", int'(rd_count), 5);
    tick();
    chk("R12 irq pulse", int'(ep_irq), 0);
    send(3, 8'h40, 0, "R9 nak single");
    chk("R11 count kept", int'(rd_count), 5);
    read(5, "R11 data");
    chk("R5 still ready", int'(ready), 1);
    clear();
    chk("R5 ready", int'(ready), 0);
    chk("R5 full", int'(full), 0);
    chk("R5 accept", int'(can_accept), 1);

    // R6 auto-release
    cfg_autoclr = 1'b1;
    send(8, 8'h20, 1, "R6 accept");
    tick();
    read(8, "R6 data");
    chk("R6 auto ready", int'(ready), 0);
    chk("R6 auto full", int'(full), 0);
    send(3, 8'h30, 1, "R6 accept short");
    tick();
    read(3, "R6 short data");
    tick();
    chk("R6 short stays", int'(ready), 1);
    clear();
    cfg_autoclr = 1'b0;

    // R11 oversize packet is truncated
    send(10, 8'h50, 1, "R11 accept");
    tick();
    chk("R11 truncated", int'(rd_count), 8);
    read(8, "R11 trunc data");
    clear();

    // R1 / R4 double mode
    dbl_off_we = 1'b1; dbl_off_val = 1'b0;
    tick();
    dbl_off_we = 1'b0;
    chk("R1 dbl on", int'(dbl_mode), 1);
    send(4, 8'h60, 1, "R4 accept1");
    tick();
    chk("R4 ready", int'(ready), 1);
    chk("R4 full clear", int'(full), 0);
    chk("R12 irq dbl", int'(ep_irq), 1);
    send(6, 8'h70, 1, "R4 accept2");
    chk("R4 full", int'(full), 1);
    chk("R9 accept", int'(can_accept), 0);
    send(2, 8'h80, 0, "R9 nak dbl");
    read(2, "R10 partial");
    clear();
    chk("R7 full drop", int'(full), 0);
    chk("R7 ready drop", int'(ready), 0);
    tick();
    chk("R7 ready again", int'(ready), 1);
    chk("R7 irq", int'(ep_irq), 1);
    chk("R7 count", int'(rd_count), 6);
    void'(exp_q.pop_front());
    void'(exp_q.pop_front());
    read(6, "R10 next packet");
    clear();
    tick();
    chk("R5 dbl empty", int'(ready), 0);

    // R1 size rule forces single mode
    cfg_maxpkt = SW'(12); cur_max = 12;
    tick();
    chk("R1 size rule", int'(dbl_mode), 0);
    send(10, 8'hA0, 1, "R1 accept");
    tick();
    chk("R1 full single", int'(full), 1);
    read(10, "R1 data");
    clear();

    // R8 configuration error
    cfg_maxpkt = SW'(20);
    tick();
    chk("R8 err big", int'(cfg_err), 1);
    chk("R8 accept", int'(can_accept), 0);
    cfg_maxpkt = SW'(0);
    tick();
    chk("R8 err zero", int'(cfg_err), 1);
    cfg_maxpkt = SW'(8); cur_max = 8;
    tick();
    chk("R8 err clear", int'(cfg_err), 0);
    chk("R1 dbl back", int'(dbl_mode), 1);
    chk("R11 queue empty", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule